// File: doc/BRIEF.md
# Power-up Strap Latch and Test-Mode Control

This block captures the board configuration straps of a clock generator exactly once, when the active-low power-good input first goes active after a power-on reset. The captured values are held as readback bits: three frequency-select bits and one bit that gives a shared differential pair its function. After capture, later strap activity has no effect until the next power-on reset.

The block also decides how the clock outputs behave. They can run normally, go high-impedance, or carry a divided reference clock. Test mode can be requested in two ways. The first is a strap: the three-level select input read above its high threshold at capture. The second is a register bit written by software at any time after reset. Test mode is sticky, and only a power-on reset leaves it. When software has entered test mode, a second register bit chooses the test output and the live mode pin is ignored. When test mode comes only from the strap, the live (unlatched) frequency-select-B pin chooses the test output.

Three-level detection is done outside the block by two comparator results. All pin inputs pass through a synchronizer before use.

Top module: `pwrup_strap_ctrl`

## Requirements
- R1: During and after power-on reset, and before power-good has gone active, `fs_rb_o` reads 3'b000, `pair_cpu_o` reads 0 and `out_mode_o` reads 2'b00, whatever the strap pins show.
- R2: On the first activation of `pwrgd_n` (driven low), the straps are captured into the readback. The bits are `fs_rb_o[2]` = third select, `fs_rb_o[1]` = `fsb_i`, `fs_rb_o[0]` = `fsa_i`.
- R3: After capture, changes on any strap pin and any further toggling of `pwrgd_n` leave `fs_rb_o` and `pair_cpu_o` unchanged until the next power-on reset.
- R4: If `sel_hi_i` is 1 at capture, hardware test mode is latched and `fs_rb_o[2]` reads 0. If `sel_hi_i` is 0, `fs_rb_o[2]` takes `sel_lvl_i` and no test mode is latched.
- R5: `pair_cpu_o` takes the captured `pair_strap_i`. A 1 selects the debug CPU clock and a 0 selects an extra SRC clock.
- R6: In hardware test mode without software entry, `out_mode_o` follows the live `fsb_i`. A 0 gives 2'b01 (high-impedance) and a 1 gives 2'b10 (divided reference), and the output keeps tracking the pin after capture.
- R7: Writing `sw_test_enter_i` = 1 enters test mode. `out_mode_o` is then 2'b01 when `sw_test_ref_i` = 0 and 2'b10 when it is 1, and `fsb_i` has no effect.
- R8: Clearing `sw_test_enter_i` does not leave test mode. Only power-on reset returns `out_mode_o` to 2'b00.
- R9: With no test mode entered, `out_mode_o` stays 2'b00 whatever `fsb_i` and `sw_test_ref_i` do.
- R10: When both the strap and software have entered test mode, `sw_test_ref_i` alone picks the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| pwrgd_n | input | 1 | Power-good, active low; its first activation triggers capture |
| sel_hi_i | input | 1 | Three-level select strap is above the test threshold |
| sel_lvl_i | input | 1 | Three-level select strap read as a frequency-select bit |
| fsb_i | input | 1 | Frequency-select B strap; also the live test-output pin |
| fsa_i | input | 1 | Frequency-select A strap |
| pair_strap_i | input | 1 | Shared-pair function strap |
| sw_test_enter_i | input | 1 | Register bit: enter test mode |
| sw_test_ref_i | input | 1 | Register bit: test output choice under software entry |
| fs_rb_o | output | 3 | Latched frequency-select readback |
| pair_cpu_o | output | 1 | Latched pair function, 1 = debug CPU clock |
| out_mode_o | output | 2 | 00 normal, 01 high-impedance, 10 divided reference |

## Verification
Software test entry and strap capture can fall in the same cycle. The bench provokes this by setting the software entry bit with a low reference choice at the same edge that power-good is driven active, with a test-level strap and the live pin high. It then judges that the output settles to high-impedance (2'b01) and never to the divided reference that the live pin would select. A second case writes the software bit after the strap has already selected test mode and checks that the register choice takes over.

// File: rtl/strapctl_pkg.sv
package strapctl_pkg;

  localparam int STRAP_W = 5;
  localparam int FS_W    = 3;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_HIZ    = 2'b01,
    MODE_REFDIV = 2'b10
  } out_mode_e;

  typedef struct packed {
    logic sel_hi;
    logic sel_lvl;
    logic fs_b;
    logic fs_a;
    logic pair;
  } strap_t;

endpackage

// File: rtl/strapctl_sync.sv
module strapctl_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;

  always_comb begin
    stg_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) begin
      stg_d[s] = stg_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) begin
        stg_q[s] <= RST_VAL;
      end
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q_o = stg_q[LAST];

endmodule

// File: rtl/strapctl_latch.sv
module strapctl_latch
  import strapctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pg_active_i,
  input  strap_t          strap_i,
  output logic [FS_W-1:0] fs_o,
  output logic            pair_o,
  output logic            hw_test_o
);

  logic            captured_q, captured_d;
  logic            cap_en;
  logic [FS_W-1:0] fs_q, fs_d;
  logic            pair_q, pair_d;
  logic            test_q, test_d;

  // capture enable: first cycle with power-good active since reset
  assign cap_en = pg_active_i & ~captured_q;

  always_comb begin
    captured_d = captured_q;
    fs_d       = fs_q;
    pair_d     = pair_q;
    test_d     = test_q;
    if (cap_en) begin
      captured_d = 1'b1;
      test_d     = strap_i.sel_hi;
      // a test-level strap is not a frequency-select bit
      fs_d       = {strap_i.sel_lvl & ~strap_i.sel_hi, strap_i.fs_b, strap_i.fs_a};
      pair_d     = strap_i.pair;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      captured_q <= 1'b0;
      fs_q       <= '0;
      pair_q     <= 1'b0;
      test_q     <= 1'b0;
    end else if (cap_en) begin
      captured_q <= captured_d;
      fs_q       <= fs_d;
      pair_q     <= pair_d;
      test_q     <= test_d;
    end
  end

  assign fs_o      = fs_q;
  assign pair_o    = pair_q;
  assign hw_test_o = test_q;

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (captured_q && $past(captured_q)) |-> ($stable(fs_q) && $stable(pair_q) && $stable(test_q)));

  p_fs_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    test_q |-> !fs_q[FS_W-1]);

  p_no_early_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !captured_q |-> (fs_q == '0 && !pair_q && !test_q));

endmodule

// File: rtl/strapctl_mode.sv
module strapctl_mode
  import strapctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hw_test_i,
  input  logic      live_pin_i,
  input  logic      sw_enter_i,
  input  logic      sw_ref_i,
  output out_mode_e mode_o
);

  logic      sw_flag_q, sw_flag_d;
  out_mode_e mode_q, mode_d;

  // sticky software entry; only reset clears it
  assign sw_flag_d = sw_flag_q | sw_enter_i;

  always_comb begin
    if (sw_flag_q) begin
      mode_d = sw_ref_i ? MODE_REFDIV : MODE_HIZ;
    end else if (hw_test_i) begin
      mode_d = live_pin_i ? MODE_REFDIV : MODE_HIZ;
    end else begin
      mode_d = MODE_NORMAL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_flag_q <= 1'b0;
      mode_q    <= MODE_NORMAL;
    end else begin
      sw_flag_q <= sw_flag_d;
      mode_q    <= mode_d;
    end
  end

  assign mode_o = mode_q;

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_flag_q |=> sw_flag_q);

  p_sw_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_flag_q |=> (mode_q != MODE_NORMAL));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_flag_q && !hw_test_i) |=> (mode_q == MODE_NORMAL));

  p_test_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_NORMAL) |=> (mode_q != MODE_NORMAL));

endmodule

// File: rtl/pwrup_strap_ctrl.sv
module pwrup_strap_ctrl
  import strapctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwrgd_n,
  input  logic       sel_hi_i,
  input  logic       sel_lvl_i,
  input  logic       fsb_i,
  input  logic       fsa_i,
  input  logic       pair_strap_i,
  input  logic       sw_test_enter_i,
  input  logic       sw_test_ref_i,
  output logic [2:0] fs_rb_o,
  output logic       pair_cpu_o,
  output logic [1:0] out_mode_o
);

  localparam int PIN_W = STRAP_W + 1;
  localparam logic [PIN_W-1:0] PIN_RST = {1'b1, {STRAP_W{1'b0}}};

  logic             rst_sync_n;
  logic [PIN_W-1:0] pins_raw, pins_sync;
  strap_t           strap_sync;
  logic             pg_active;
  logic             hw_test;
  out_mode_e        mode;

  strapctl_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (1'b1),
    .q_o   (rst_sync_n)
  );

  assign pins_raw = {pwrgd_n, sel_hi_i, sel_lvl_i, fsb_i, fsa_i, pair_strap_i};

  strapctl_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (pins_raw),
    .q_o   (pins_sync)
  );

  assign pg_active  = ~pins_sync[PIN_W-1];
  assign strap_sync = strap_t'(pins_sync[STRAP_W-1:0]);

  strapctl_latch u_latch (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .pg_active_i (pg_active),
    .strap_i     (strap_sync),
    .fs_o        (fs_rb_o),
    .pair_o      (pair_cpu_o),
    .hw_test_o   (hw_test)
  );

  strapctl_mode u_mode (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .hw_test_i  (hw_test),
    .live_pin_i (strap_sync.fs_b),
    .sw_enter_i (sw_test_enter_i),
    .sw_ref_i   (sw_test_ref_i),
    .mode_o     (mode)
  );

  assign out_mode_o = mode;

endmodule

// File: tb/sim_pwrup_strap_ctrl.sv
module sim_pwrup_strap_ctrl;

  logic       clk = 1'b0;
  logic       rst_n, pwrgd_n, sel_hi_i, sel_lvl_i, fsb_i, fsa_i, pair_strap_i;
  logic       sw_test_enter_i, sw_test_ref_i;
  logic [2:0] fs_rb_o;
  logic       pair_cpu_o;
  logic [1:0] out_mode_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  pwrup_strap_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .pwrgd_n(pwrgd_n), .sel_hi_i(sel_hi_i),
    .sel_lvl_i(sel_lvl_i), .fsb_i(fsb_i), .fsa_i(fsa_i), .pair_strap_i(pair_strap_i),
    .sw_test_enter_i(sw_test_enter_i), .sw_test_ref_i(sw_test_ref_i),
    .fs_rb_o(fs_rb_o), .pair_cpu_o(pair_cpu_o), .out_mode_o(out_mode_o)
  );

  // [10:6] straps {sel_hi, sel_lvl, fsb, fsa, pair}, [5:3] fs, [2] pair, [1:0] mode
  localparam logic [10:0] VEC [6] = '{
    11'b00000_000_0_00,
    11'b01011_101_1_00,
    11'b01110_111_0_00,
    11'b11011_001_1_01,
    11'b10100_010_0_10,
    11'b00101_010_1_00
  };

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_straps(input logic [4:0] s);
    {sel_hi_i, sel_lvl_i, fsb_i, fsa_i, pair_strap_i} = s;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pwrgd_n = 1'b1; sw_test_enter_i = 1'b0; sw_test_ref_i = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
  endtask

  initial begin
    rst_n = 1'b0; pwrgd_n = 1'b1; set_straps(5'b00000);
    sw_test_enter_i = 1'b0; sw_test_ref_i = 1'b0;
    wait_cyc(1);

    // R1: reset state with busy straps, power-good not yet active
    set_straps(5'b11111);
    do_reset();
    wait_cyc(4);
    check("R1 fs", fs_rb_o, 0);
    check("R1 pair", pair_cpu_o, 0);
    check("R1 mode", out_mode_o, 0);

    // table walk: R2 R4 R5 R6
    for (int i = 0; i < 6; i++) begin
      set_straps(VEC[i][10:6]);
      do_reset();
      pwrgd_n = 1'b0;
      wait_cyc(7);
      check("R2/R4 fs readback", fs_rb_o, VEC[i][5:3]);
      check("R5 pair", pair_cpu_o, VEC[i][2]);
      check("R4/R6 mode", out_mode_o, VEC[i][1:0]);
    end

    // R3: straps move, power-good toggles, readback unchanged (last vector: 010, pair 1)
    set_straps(5'b01011);
    pwrgd_n = 1'b1; wait_cyc(5);
    pwrgd_n = 1'b0; wait_cyc(7);
    check("R3 fs held", fs_rb_o, 3'b010);
    check("R3 pair held", pair_cpu_o, 1);

    // R9: no test entered; live pin and ref bit do nothing
    fsb_i = 1'b1; sw_test_ref_i = 1'b1; wait_cyc(5);
    check("R9 mode normal", out_mode_o, 0);
    fsb_i = 1'b0; wait_cyc(5);
    check("R9 mode normal pin low", out_mode_o, 0);

    // R7: software entry, ref=1 then ref=0, live pin ignored
    sw_test_enter_i = 1'b1; sw_test_ref_i = 1'b1; wait_cyc(4);
    check("R7 sw ref", out_mode_o, 2);
    sw_test_ref_i = 1'b0; wait_cyc(4);
    check("R7 sw hiz", out_mode_o, 1);
    fsb_i = 1'b1; wait_cyc(5);
    check("R7 pin ignored", out_mode_o, 1);

    // R8: clearing entry bit keeps test mode; reset leaves it
    sw_test_enter_i = 1'b0; sw_test_ref_i = 1'b1; wait_cyc(4);
    check("R8 sticky", out_mode_o, 2);
    do_reset();
    wait_cyc(2);
    check("R8 reset exits", out_mode_o, 0);

    // R6: strap test, live pin tracked both ways
    set_straps(5'b10000);
    pwrgd_n = 1'b0; wait_cyc(7);
    check("R6 pin low hiz", out_mode_o, 1);
    fsb_i = 1'b1; wait_cyc(5);
    check("R6 pin high ref", out_mode_o, 2);
    fsb_i = 1'b0; wait_cyc(5);
    check("R6 pin low again", out_mode_o, 1);

    // R10: software entry after strap entry takes over
    fsb_i = 1'b1; sw_test_enter_i = 1'b1; sw_test_ref_i = 1'b0; wait_cyc(5);
    check("R10 sw over strap", out_mode_o, 1);

    // R10: software entry in the same cycle as capture
    set_straps(5'b10100);
    do_reset();
    sw_test_enter_i = 1'b1; sw_test_ref_i = 1'b0; pwrgd_n = 1'b0;
    wait_cyc(7);
    check("R10 same-cycle entry", out_mode_o, 1);
    check("R4 fs masked", fs_rb_o, 3'b010);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule